// File: doc/BRIEF.md
# Mode-Configurable Bidirectional Registered Transceiver

This block is a bit-parallel transceiver core. It sits between a card-side pair of buses, with separate inbound and outbound wires, and a shared backplane bus. Each direction has its own logic element. A 2-bit mode input selects, at run time, whether that element is a plain buffer, a rising-edge register or an active-high transparent latch. The direction's clock pin serves as the register clock or as the latch enable. Data is inverted each time it crosses between the card side and the backplane side.

The backplane side is open-drain. The block does not drive a tri-state net. It reports which lines it pulls low (`b_pull_low`) and reads the resolved wired-AND level back on `b_in`. The card-side output carries its value on `a_out`, and `a_out_oe` marks whether it is driven or high-impedance.

A loopback select feeds the outbound element's result straight into the inbound element, in place of the backplane level. Diagnostic software can then read back the outbound data without using the backplane.

Top module: `bidir_mode_xcvr`

## Requirements
- R1: Each direction decodes its own 2-bit mode: 2'b00 selects buffer, 2'b01 selects rising-edge register and 2'b1x selects transparent latch. `mode_ab` configures the card-to-backplane element and `mode_ba` configures the backplane-to-card element.
- R2: In latch mode the element follows its input while its clock pin is high. It keeps the last followed value while the pin is low.
- R3: In register mode the element loads its input on the rising edge of its clock pin. Input changes at any other time do not affect it.
- R4: The outbound element receives the inverse of `a_in`. Bit i of `b_pull_low` is 1 (line pulled low) exactly when that element's output bit is 0 and the backplane drive is enabled. With loopback low, the inbound element receives `b_in`, and `a_out` is the inverse of the inbound element's output.
- R5: With `loopback` high, the inbound element receives the outbound element's output instead of `b_in`, so `a_out` follows `a_in` with no net inversion.
- R6: `a_out_oe` is 1 (driven) when `oe_ba` is 1 and 0 (high-impedance) when `oe_ba` is 0.
- R7: The backplane is driven only when `oe_ab` is 1 and `oe_ab_n` is 0. In the other three combinations `b_pull_low` is all zeros.
- R8: Both elements load and hold data whatever the state of the output enables. Data captured while the outputs are disabled appears when the enables are turned on.
- R9: An asynchronous active-low `rst_n` clears the stored register and latch values of both directions to 0.
- R10: With both modes set to buffer, loopback low and the backplane drive enabled, the block is combinationally transparent both ways: `b_pull_low` equals `a_in` and `a_out` equals the inverse of `b_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Outbound element clock / latch enable |
| clk_ba | input | 1 | Inbound element clock / latch enable |
| rst_n | input | 1 | Asynchronous active-low clear of stored data |
| mode_ab | input | 2 | Outbound element mode (00 buffer, 01 register, 1x latch) |
| mode_ba | input | 2 | Inbound element mode (00 buffer, 01 register, 1x latch) |
| loopback | input | 1 | 1: inbound element reads the outbound element's output |
| oe_ab | input | 1 | Backplane drive enable, active high |
| oe_ab_n | input | 1 | Backplane drive enable, active low |
| oe_ba | input | 1 | Card-side output enable |
| a_in | input | W | Card-side inbound data |
| a_out | output | W | Card-side outbound data value |
| a_out_oe | output | 1 | 1 when `a_out` is driven, 0 when high-impedance |
| b_in | input | W | Resolved backplane level as sensed |
| b_pull_low | output | W | Per-line open-drain pull-down request |

## Verification
The sweep covers all sixteen mode pairs, both loopback settings and all eight enable combinations. State carries from one configuration to the next, so values captured under one setting must show up correctly under the next. Every step changes the input while the clocks are high. A register that behaves like a latch would then follow the mid-phase change. A latch that behaves like a register would miss it.

External pull-downs on the sensed backplane show whether the inbound path reads the wired level or wrongly reads its own drive. Loopback with the outbound element in register mode checks that the inbound register captures the freshly loaded value, because its edge comes later. A wrong select would show inverted or stale data on `a_out`. The bench also checks the reset clear in both stored modes, and that data captured with every enable off appears once the enables come on.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    ELEM_BUF   = 2'd0,
    ELEM_FLOP  = 2'd1,
    ELEM_LATCH = 2'd2
  } elem_kind_e;

  // 2'b00 buffer, 2'b01 register, 2'b1x latch
  function automatic elem_kind_e decode_mode(input logic [1:0] m);
    if (m[1])      return ELEM_LATCH;
    else if (m[0]) return ELEM_FLOP;
    else           return ELEM_BUF;
  endfunction

  // backplane drive qualifies only with the true enable high and the inverted one low
  function automatic logic drive_ok(input logic en_hi, input logic en_lo_n);
    return en_hi & ~en_lo_n;
  endfunction

endpackage

// File: rtl/xcvr_elem.sv
module xcvr_elem
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         gate,
  input  logic [1:0]   mode,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  elem_kind_e   kind;
  logic [W-1:0] flop_q;
  logic [W-1:0] latch_q;

  assign kind = decode_mode(mode);

  // register storage: loads on every rising edge, used only in register mode
  always_ff @(posedge gate or negedge rst_n) begin
    if (!rst_n) flop_q <= '0;
    else        flop_q <= d;
  end

  // latch storage: transparent while the gate is high
  always_latch begin
    if (!rst_n)    latch_q <= '0;
    else if (gate) latch_q <= d;
  end

  always_comb begin
    case (kind)
      ELEM_FLOP:  q = flop_q;
      ELEM_LATCH: q = latch_q;
      default:    q = d;
    endcase
  end

endmodule

// File: rtl/xcvr_odrain.sv
module xcvr_odrain #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] level,
  output logic [W-1:0] pull_low
);

  for (genvar i = 0; i < W; i++) begin : g_line
    // a low level on an enabled line pulls it down; anything else releases
    assign pull_low[i] = en & ~level[i];
  end

endmodule

// File: rtl/xcvr_loopsel.sv
module xcvr_loopsel #(
  parameter int W = 8
) (
  input  logic         sel_loop,
  input  logic [W-1:0] from_bus,
  input  logic [W-1:0] from_out,
  output logic [W-1:0] to_in
);

  assign to_in = sel_loop ? from_out : from_bus;

endmodule

// File: rtl/bidir_mode_xcvr.sv
module bidir_mode_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic [1:0]   mode_ab,
  input  logic [1:0]   mode_ba,
  input  logic         loopback,
  input  logic         oe_ab,
  input  logic         oe_ab_n,
  input  logic         oe_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_out_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull_low
);

  logic [W-1:0] ab_d;        // inverted card data into the outbound element
  logic [W-1:0] p_node;      // outbound element result, level placed on the backplane
  logic [W-1:0] q_node;      // inbound element input after the loopback select
  logic [W-1:0] r_node;      // inbound element result
  logic         b_drive_en;

  assign ab_d = ~a_in;

  xcvr_elem #(.W(W)) u_elem_ab (
    .rst_n (rst_n),
    .gate  (clk_ab),
    .mode  (mode_ab),
    .d     (ab_d),
    .q     (p_node)
  );

  assign b_drive_en = drive_ok(oe_ab, oe_ab_n);

  xcvr_odrain #(.W(W)) u_odrain (
    .en       (b_drive_en),
    .level    (p_node),
    .pull_low (b_pull_low)
  );

  xcvr_loopsel #(.W(W)) u_loopsel (
    .sel_loop (loopback),
    .from_bus (b_in),
    .from_out (p_node),
    .to_in    (q_node)
  );

  xcvr_elem #(.W(W)) u_elem_ba (
    .rst_n (rst_n),
    .gate  (clk_ba),
    .mode  (mode_ba),
    .d     (q_node),
    .q     (r_node)
  );

  assign a_out    = ~r_node;
  assign a_out_oe = oe_ba;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic [1:0]   mode_ab,
  input logic [1:0]   mode_ba,
  input logic         loopback,
  input logic         oe_ab,
  input logic         oe_ab_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_pull_low,
  input logic [W-1:0] p_node
);

  logic seen_ab;
  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) seen_ab <= 1'b0;
    else        seen_ab <= 1'b1;
  end

  // R3: the register shows what it loaded one edge earlier
  a_r3_flop_load: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (seen_ab && mode_ab == 2'b01) |-> (p_node == ~$past(a_in)));

  // R2: at the end of an open phase the latch carries the current input
  a_r2_latch_follow: assert property (@(negedge clk_ab) disable iff (!rst_n)
    mode_ab[1] |-> (p_node == ~a_in));

  // R7: no pull-down unless both enables are in their active state
  a_r7_b_idle: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(oe_ab && !oe_ab_n) |-> (b_pull_low == '0));

  // R5: loopback through two buffers returns the card data uninverted
  a_r5_loop_path: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (loopback && mode_ab == 2'b00 && mode_ba == 2'b00) |-> (a_out == a_in));

  // R10: fully transparent configuration in both directions
  a_r10_transparent: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (mode_ab == 2'b00 && mode_ba == 2'b00 && !loopback && oe_ab && !oe_ab_n)
      |-> (b_pull_low == a_in && a_out == ~b_in));

endmodule

bind bidir_mode_xcvr xcvr_checker #(.W(W)) u_chk (
  .clk_ab     (clk_ab),
  .clk_ba     (clk_ba),
  .rst_n      (rst_n),
  .mode_ab    (mode_ab),
  .mode_ba    (mode_ba),
  .loopback   (loopback),
  .oe_ab      (oe_ab),
  .oe_ab_n    (oe_ab_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .b_in       (b_in),
  .b_pull_low (b_pull_low),
  .p_node     (p_node)
);

// File: tb/bidir_mode_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_mode_xcvr_tb_top;
  localparam int W = 8;

  logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic [1:0]   mode_ab = 2'b00, mode_ba = 2'b00;
  logic         loopback = 1'b0, oe_ab = 1'b0, oe_ab_n = 1'b1, oe_ba = 1'b0;
  logic [W-1:0] a_in = '0, ext_low = '0;
  wire  [W-1:0] b_in, b_pull_low, a_out;
  wire          a_out_oe;

  // wired-AND backplane with pull-up: any pull-down wins
  assign b_in = ~b_pull_low & ~ext_low;

  bidir_mode_xcvr #(.W(W)) dut_i (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .mode_ab(mode_ab), .mode_ba(mode_ba), .loopback(loopback),
    .oe_ab(oe_ab), .oe_ab_n(oe_ab_n), .oe_ba(oe_ba),
    .a_in(a_in), .a_out(a_out), .a_out_oe(a_out_oe),
    .b_in(b_in), .b_pull_low(b_pull_low)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // independent model of stored values
  logic [W-1:0] m_ab_ff = '0, m_ab_lat = '0, m_ba_ff = '0, m_ba_lat = '0;

  function automatic logic [W-1:0] pick(input logic [1:0] m, input logic [W-1:0] d,
                                        input logic [W-1:0] ff, input logic [W-1:0] lat);
    if (m[1]) return lat;
    if (m[0]) return ff;
    return d;
  endfunction

  function automatic logic [W-1:0] exp_p();
    return pick(mode_ab, ~a_in, m_ab_ff, m_ab_lat);
  endfunction

  function automatic logic [W-1:0] exp_pull(input logic [W-1:0] p);
    return (oe_ab == 1'b1 && oe_ab_n == 1'b0) ? ~p : '0;
  endfunction

  function automatic logic [W-1:0] exp_q(input logic [W-1:0] p);
    return loopback ? p : (~exp_pull(p) & ~ext_low);
  endfunction

  task automatic check_vec(input string req, input string what,
                           input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (mab=%b mba=%b lb=%b oe=%b%b%b)",
               req, what, got, exp, mode_ab, mode_ba, loopback, oe_ab, oe_ab_n, oe_ba);
    end
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] p, q;
    p = exp_p();
    q = exp_q(p);
    check_vec({req, (oe_ab && !oe_ab_n) ? " R4" : " R7"}, "b_pull_low", b_pull_low, exp_pull(p));
    check_vec({req, loopback ? " R5" : " R4"}, "a_out", a_out,
              ~pick(mode_ba, q, m_ba_ff, m_ba_lat));
    check_vec("R6", "a_out_oe", {{(W-1){1'b0}}, a_out_oe}, {{(W-1){1'b0}}, oe_ba});
  endtask

  // one 4 ns cycle: inputs set while both clocks low, changed again while both high
  task automatic step(input logic [W-1:0] x0, input logic [W-1:0] e0,
                      input logic [W-1:0] x1, input logic [W-1:0] e1, input string tag);
    logic [W-1:0] p, q;
    a_in = x0; ext_low = e0;
    #0.5 check_all({tag, " R1 R2 R3 pre-edge"});
    #0.5 clk_ab = 1'b1; m_ab_ff = ~x0; m_ab_lat = ~x0;
    #0.5 clk_ba = 1'b1;
    p = exp_p(); q = exp_q(p); m_ba_ff = q; m_ba_lat = q;
    #0.5 check_all({tag, " R1 R3 after-edge"});
    #0.25 a_in = x1; ext_low = e1;
    m_ab_lat = ~x1; p = exp_p(); q = exp_q(p); m_ba_lat = q;
    #0.5 check_all({tag, " R2 R3 mid-high"});
    #0.25 clk_ab = 1'b0;
    #0.5 clk_ba = 1'b0;
    #0.5;
  endtask

  task automatic set_cfg(input logic [1:0] mab, input logic [1:0] mba, input logic lb,
                         input logic [2:0] oes);
    mode_ab = mab; mode_ba = mba; loopback = lb;
    {oe_ab, oe_ab_n, oe_ba} = oes;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset clears both stored values, observed in register and latch modes
    set_cfg(2'b01, 2'b01, 1'b0, 3'b101);
    a_in = 8'h5A; ext_low = '0;
    #1 rst_n = 1'b0;
    #1 rst_n = 1'b1;
    #1;
    check_vec("R9", "b_pull_low reg", b_pull_low, {W{1'b1}});
    check_vec("R9", "a_out reg", a_out, {W{1'b1}});
    mode_ab = 2'b10; mode_ba = 2'b11;
    #1;
    check_vec("R9", "b_pull_low latch", b_pull_low, {W{1'b1}});
    check_vec("R9", "a_out latch", a_out, {W{1'b1}});

    // R10: transparent both ways, including an external pull-down
    set_cfg(2'b00, 2'b00, 1'b0, 3'b101);
    step(8'hC3, 8'h00, 8'h3C, 8'h81, "R10");
    #0.1;
    check_vec("R10", "b_pull_low", b_pull_low, a_in);
    check_vec("R10", "a_out", a_out, ~b_in);
    #0.1;

    // R8: capture with all enables off, then enable and observe stored data
    set_cfg(2'b01, 2'b01, 1'b1, 3'b010);
    step(8'hA7, 8'h00, 8'h11, 8'h00, "R8");
    check_vec("R8", "b_pull_low disabled", b_pull_low, '0);
    set_cfg(2'b01, 2'b01, 1'b1, 3'b101);
    #0.5;
    check_vec("R8", "b_pull_low enabled", b_pull_low, 8'hA7);
    check_vec("R8", "a_out enabled", a_out, 8'hA7);
    #0.5;

    // exhaustive configuration sweep, state carried between configurations
    for (int c = 0; c < 256; c++) begin
      set_cfg(c[1:0], c[3:2], c[4], c[7:5]);
      for (int v = 0; v < 3; v++) begin
        logic [W-1:0] x0, x1, e0, e1;
        x0 = W'(c * 29 + v * 83 + 17);
        x1 = W'(c * 53 + v * 41 + 99);
        e0 = (v == 2) ? W'(c * 7) & 8'h0F : '0;
        e1 = (v == 1) ? W'(c * 11) & 8'hF0 : '0;
        step(x0, e0, x1, e1, "sweep");
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule